// File: doc/BRIEF.md
# MDIO Command Engine

This block runs one clause-22 management transaction towards an external PHY each time software launches it through a small 32-bit register port. Software first writes the value to send into the data register. It then writes the command register with the start flag set, an access code, a PHY address and a register number. The engine generates the management clock (MDC) and shifts the complete frame out on MDIO. For a read, it releases the line during the turnaround and data phases and collects the sixteen bits the PHY returns.

The start flag stays set for the whole transaction and clears itself at the end, so software polls it to find out when the access is done. A completed read leaves the PHY's answer in the upper half of the data register. A launch that carries an undefined access code is dropped at once.

Top module: `mdio_cmd_engine`

## Requirements
- R1: The command register, at address `CMD_ADDR`, holds the start flag at bit 20, the access code at bits 17:16, the PHY address at bits 12:8 and the register number at bits 4:0. Every other bit reads back as zero. Reads return through `bus_rdata` one clock after `bus_addr` is presented.
- R2: Access code 01 (write) sends 64 bits, most significant first, with the line driven the whole time: 32 ones, start code 01, the access code, the PHY address, the register number, turnaround 10, and then bits 15:0 of the data register.
- R3: Access code 10 (read) drives the first 46 bits (preamble, start code, access code, PHY address, register number). It then releases MDIO (`mdio_oe_o` low) for the two turnaround bits and the sixteen data bits.
- R4: During a read, MDIO is sampled at each rising MDC edge of the data phase. When the access completes, the 16 bits, first received at bit 31, are stored into bits 31:16 of the data register at address `CMD_ADDR`+1. Bits 15:0 of that register are kept.
- R5: After a valid launch, the start flag stays set for exactly 64×`MDC_DIV` clock cycles and then clears by itself.
- R6: A command write with the start flag set and access code 00 or 11 leaves the start flag clear. It produces no MDC edge and never asserts `mdio_oe_o`. The other fields are still stored.
- R7: MDC has a period of `MDC_DIV` clocks and is high in the second half of each bit. It is low and `mdio_oe_o` is low whenever no transaction runs. MDIO output changes only together with a falling MDC edge.
- R8: While a transaction runs, writes to either register are ignored. The frame and the register contents are unaffected.
- R9: After reset the command register reads zero, MDC is low and MDIO is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data for `bus_addr` |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench builds the engine with `MDC_DIV` = 4, which keeps each frame to 256 cycles. This makes a full cross of all four access codes, the ten PHY addresses in use and three register numbers affordable, with every frame bit-compared against one assembled arithmetically in the bench. The short divider also lets every MDC period and the exact busy length be measured on every transaction. A PHY responder returns a value derived from the address pair, so each read-back result is unique to its access.

// File: rtl/mdio_eng_pkg.sv
package mdio_eng_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_FIRST   = 46;   // first turnaround bit index
  localparam int DATA_FIRST = 48;   // first data bit index
  localparam int START_POS  = 20;

  typedef enum logic [1:0] {
    OP_RSV0  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_RSV3  = 2'b11
  } mgmt_op_e;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input mgmt_op_e    op,
    input logic [4:0]  phy,
    input logic [4:0]  regn,
    input logic [15:0] wdat
  );
    logic [1:0]  ta;
    logic [15:0] body;
    ta   = (op == OP_READ) ? 2'b11 : 2'b10;
    body = (op == OP_READ) ? 16'hFFFF : wdat;
    return {32'hFFFF_FFFF, 2'b01, op, phy, regn, ta, body};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic rise_tick,
  output logic fall_tick,
  output logic mdc
);
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)              cnt <= '0;
    else if (cnt == CW'(DIV - 1)) cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end

  assign rise_tick = run && (cnt == CW'(HALF - 1));
  assign fall_tick = run && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run)    mdc <= 1'b0;
    else if (rise_tick) mdc <= 1'b1;
    else if (fall_tick) mdc <= 1'b0;
  end

  // R7: MDC only rises on a scheduled rising point
  a_r7_mdc_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> $past(rise_tick));
  // R7: MDC parks low once the engine stops
  a_r7_mdc_idle_low: assert property (@(posedge clk) disable iff (rst)
    !run |=> !mdc);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_eng_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  launch,
  input  logic                  is_read_in,
  input  logic [FRAME_BITS-1:0] frame_in,
  input  logic                  rise_tick,
  input  logic                  fall_tick,
  input  logic                  mdio_i,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic                  done,
  output logic [15:0]           rd_word
);
  localparam int CW = $clog2(FRAME_BITS);

  logic                  active;
  logic                  rd_mode;
  logic [CW-1:0]         bit_idx;
  logic [CW-1:0]         next_idx;
  logic [FRAME_BITS-1:0] shreg;

  assign next_idx = bit_idx + 1'b1;
  assign done     = active && fall_tick && (bit_idx == CW'(FRAME_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      rd_mode <= 1'b0;
      bit_idx <= '0;
      shreg   <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      rd_word <= '0;
    end else if (launch) begin
      active  <= 1'b1;
      rd_mode <= is_read_in;
      bit_idx <= '0;
      mdio_o  <= frame_in[FRAME_BITS-1];
      shreg   <= frame_in << 1;
      mdio_oe <= 1'b1;
    end else if (active) begin
      if (rise_tick && rd_mode && (bit_idx >= CW'(DATA_FIRST)))
        rd_word <= {rd_word[14:0], mdio_i};
      if (done) begin
        active  <= 1'b0;
        mdio_o  <= 1'b0;
        mdio_oe <= 1'b0;
      end else if (fall_tick) begin
        bit_idx <= next_idx;
        mdio_o  <= shreg[FRAME_BITS-1];
        shreg   <= shreg << 1;
        mdio_oe <= !(rd_mode && (next_idx >= CW'(TA_FIRST)));
      end
    end
  end

  // R3: line released through turnaround and data of a read
  a_r3_read_released: assert property (@(posedge clk) disable iff (rst)
    (active && rd_mode && bit_idx >= CW'(TA_FIRST)) |-> !mdio_oe);
  // R2: a write keeps the line driven for the whole frame
  a_r2_write_driven: assert property (@(posedge clk) disable iff (rst)
    (active && !rd_mode) |-> mdio_oe);
  // R7: output bit holds between falling points
  a_r7_bit_holds: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active) && !$past(fall_tick)) |-> $stable(mdio_o));
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_eng_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int CMD_ADDR = 'h200,
  parameter int MDC_DIV  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(CMD_ADDR);
  localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(CMD_ADDR + 1);

  logic        start_q;
  mgmt_op_e    op_q;
  logic [4:0]  phy_q, reg_q;
  logic [31:0] data_q;
  logic [31:0] cmd_view;

  logic     hit_cmd, hit_dat, op_ok, launch;
  mgmt_op_e new_op;
  logic     rise_tick, fall_tick, seq_done;
  logic [15:0] rd_word;
  logic [FRAME_BITS-1:0] frame;

  assign new_op  = mgmt_op_e'(bus_wdata[17:16]);
  assign hit_cmd = bus_wr && (bus_addr == CMD_A) && !start_q;
  assign hit_dat = bus_wr && (bus_addr == DAT_A) && !start_q;
  assign op_ok   = (new_op == OP_WRITE) || (new_op == OP_READ);
  assign launch  = hit_cmd && bus_wdata[START_POS] && op_ok;
  assign frame   = build_frame(new_op, bus_wdata[12:8], bus_wdata[4:0], data_q[15:0]);

  assign cmd_view = {11'b0, start_q, 2'b0, op_q, 3'b0, phy_q, 3'b0, reg_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q   <= 1'b0;
      op_q      <= OP_RSV0;
      phy_q     <= '0;
      reg_q     <= '0;
      data_q    <= '0;
      bus_rdata <= '0;
    end else begin
      if (hit_cmd) begin
        op_q    <= new_op;
        phy_q   <= bus_wdata[12:8];
        reg_q   <= bus_wdata[4:0];
        start_q <= launch;
      end else if (seq_done) begin
        start_q <= 1'b0;
      end
      if (hit_dat)
        data_q <= bus_wdata;
      else if (seq_done && op_q == OP_READ)
        data_q[31:16] <= rd_word;
      bus_rdata <= (bus_addr == DAT_A) ? data_q : cmd_view;
    end
  end

  mdio_mdc_gen #(.DIV(MDC_DIV)) u_mdc (
    .clk(clk), .rst(rst), .run(start_q),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdc(mdc_o)
  );

  mdio_frame_seq u_seq (
    .clk(clk), .rst(rst), .launch(launch), .is_read_in(new_op == OP_READ),
    .frame_in(frame), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe_o),
    .done(seq_done), .rd_word(rd_word)
  );

  // R6: reserved access code never leaves the start flag set
  a_r6_reserved_dropped: assert property (@(posedge clk) disable iff (rst)
    (hit_cmd && bus_wdata[START_POS] && !op_ok) |=> !start_q);
  // R5: start flag holds until the sequencer reports completion
  a_r5_start_holds: assert property (@(posedge clk) disable iff (rst)
    (start_q && !seq_done) |=> start_q);
  // R7: no clock and no drive while idle
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !start_q |-> (!mdio_oe_o && !mdc_o));
  // R8: command fields frozen during a transaction
  a_r8_busy_frozen: assert property (@(posedge clk) disable iff (rst)
    (start_q && bus_wr) |=> (op_q == $past(op_q) && phy_q == $past(phy_q)));
endmodule

// File: tb/sim_mdio_cmd_engine.sv
module sim_mdio_cmd_engine;
  localparam int DIV = 4;
  localparam int AW  = 12;
  localparam logic [AW-1:0] CMD = 12'h200;
  localparam logic [AW-1:0] DAT = 12'h201;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = CMD;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic mdc, mdio_o, mdio_oe, mdio_i = 1'b1;

  int n_checks = 0, n_fail = 0;
  int cyc = 0, last_rise = 0, rises = 0;
  bit period_bad = 0, oe_seen = 0;
  logic [63:0] cap_o, cap_oe;
  logic [15:0] resp_val = '0;

  mdio_cmd_engine #(.ADDR_W(AW), .CMD_ADDR('h200), .MDC_DIV(DIV)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc_o(mdc),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .mdio_i(mdio_i)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    if (mdio_oe) oe_seen = 1'b1;
  end

  // PHY responder: records each bit at rising MDC, answers reads after falling MDC
  always @(posedge mdc) begin
    if (rises < 64) begin
      cap_o[63-rises]  = mdio_o;
      cap_oe[63-rises] = mdio_oe;
    end
    if (rises > 0 && (cyc - last_rise) != DIV) period_bad = 1'b1;
    last_rise = cyc;
    rises++;
  end

  always @(negedge mdc) begin
    if (rises >= 48 && rises < 64) mdio_i = resp_val[15-(rises-48)];
    else mdio_i = 1'b1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = CMD;
  endtask

  task automatic reg_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_addr = CMD;
  endtask

  task automatic arm_monitor();
    rises = 0; period_bad = 1'b0; oe_seen = 1'b0;
    cap_o = '0; cap_oe = '0;
  endtask

  task automatic wait_idle(output int busy);
    busy = 0;
    for (int w = 0; w < 2000; w++) begin
      @(negedge clk);
      if (bus_rdata[20]) busy++;
      else if (busy > 0 || w > 0) break;
    end
  endtask

  function automatic logic [31:0] cmd_word(input logic [1:0] op, input logic [4:0] phy,
                                           input logic [4:0] rg);
    return {11'h7FF, 1'b1, 2'b11, op, 3'b111, phy, 3'b111, rg};  // reserved bits set
  endfunction

  function automatic logic [63:0] exp_frame(input logic [1:0] op, input logic [4:0] phy,
                                            input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, op, phy, rg, 2'b10, d};
  endfunction

  initial begin
    #(20 * 190000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int busy;
    logic [4:0] regs [3] = '{5'h00, 5'h11, 5'h1F};

    repeat (3) @(negedge clk);
    rst = 1'b0;
    reg_read(CMD, rd);
    check(rd == 32'h0, "R9", "cmd after reset", {32'h0, rd}, 64'h0);
    check(!mdc && !mdio_oe, "R9", "mdc/oe after reset", {62'h0, mdc, mdio_oe}, 64'h0);

    for (int op = 0; op < 4; op++) begin
      for (int phy = 0; phy < 10; phy++) begin
        for (int ri = 0; ri < 3; ri++) begin
          logic [4:0] rg;
          logic [15:0] wval;
          logic [63:0] ef, eoe;
          rg = regs[ri];
          wval = {phy[4:0], rg, 6'b101101};
          resp_val = ~wval ^ 16'h0F0F;
          reg_write(DAT, {16'hDEAD, wval});
          arm_monitor();
          reg_write(CMD, cmd_word(op[1:0], phy[4:0], rg));
          wait_idle(busy);
          reg_read(CMD, rd);
          check(rd == {14'h0, op[1:0], 3'b0, phy[4:0], 3'b0, rg}, "R1", "cmd readback",
                {32'h0, rd}, {32'h0, 14'h0, op[1:0], 3'b0, phy[4:0], 3'b0, rg});
          check(!mdc && !mdio_oe, "R7", "idle after access", {62'h0, mdc, mdio_oe}, 64'h0);
          if (op == 1 || op == 2) begin
            check(busy == 64 * DIV, "R5", "busy length", 64'(busy), 64'(64 * DIV));
            check(rises == 64, "R7", "mdc rising edges", 64'(rises), 64'd64);
            check(!period_bad, "R7", "mdc period", {63'h0, period_bad}, 64'h0);
            ef = exp_frame(op[1:0], phy[4:0], rg, wval);
            reg_read(DAT, rd);
            if (op == 1) begin
              check(cap_oe == '1, "R2", "write drive", cap_oe, '1);
              check(cap_o == ef, "R2", "write frame", cap_o, ef);
              check(rd == {16'hDEAD, wval}, "R2", "data kept", {32'h0, rd}, {32'h0, 16'hDEAD, wval});
            end else begin
              eoe = {{46{1'b1}}, 18'h0};
              check(cap_oe == eoe, "R3", "read release", cap_oe, eoe);
              check(cap_o[63:18] == ef[63:18], "R3", "read header",
                    {18'h0, cap_o[63:18]}, {18'h0, ef[63:18]});
              check(rd == {resp_val, wval}, "R4", "read result", {32'h0, rd},
                    {32'h0, resp_val, wval});
            end
          end else begin
            check(busy == 0, "R6", "reserved start clear", 64'(busy), 64'h0);
            check(rises == 0 && !oe_seen, "R6", "reserved no frame",
                  {31'h0, oe_seen, 32'(rises)}, 64'h0);
          end
        end
      end
    end

    // R8: writes during a transaction are ignored
    begin
      logic [63:0] ef;
      reg_write(DAT, 32'h0000_5A3C);
      arm_monitor();
      reg_write(CMD, cmd_word(2'b01, 5'd3, 5'd7));
      repeat (20) @(negedge clk);
      reg_write(CMD, cmd_word(2'b10, 5'd9, 5'd2));
      reg_write(DAT, 32'hFFFF_FFFF);
      wait_idle(busy);
      ef = exp_frame(2'b01, 5'd3, 5'd7, 16'h5A3C);
      check(cap_o == ef, "R8", "frame unchanged", cap_o, ef);
      reg_read(CMD, rd);
      check(rd == 32'h0001_0307, "R8", "cmd unchanged", {32'h0, rd}, 64'h0001_0307);
      reg_read(DAT, rd);
      check(rd == 32'h0000_5A3C, "R8", "data unchanged", {32'h0, rd}, 64'h5A3C);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule